// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block monitors sixteen general-purpose input pins, organised as two eight-bit ports, and raises one shared interrupt request when an enabled pin makes a transition of its programmed direction. Each pin passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. Every pin has its own enable bit and its own direction bit. A qualifying edge latches a per-pin pending flag. The shared request is asserted while any pending flag is set on a pin that is still enabled.

Firmware reaches the block through a small register port. The port has an address, a write strobe, write data and combinational read data. The enables, directions and pending flags are visible per port. A pending flag is cleared by writing 1 to its bit.

Each pin has a two-state machine, `gpio_edge_cell`, with these states and transitions:
- **PIN_CLEAR → PIN_PENDING** ("set"): taken on a qualifying edge.
- **PIN_PENDING → PIN_CLEAR** ("clear"): taken on a write-one-to-clear, but only if no qualifying edge arrives in the same cycle.
- Every other case keeps the current state.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all enable bits read 0, all direction bits read 0 (rising edge), all pending bits read 0, and `irq` is low.
- R2: Address 0 holds the port 0 enables and address 1 the port 1 enables. Address 2 holds the port 0 directions and address 3 the port 1 directions. Bit i of each register belongs to pin i of that port. Each register reads back the value last written to it.
- R3: If a pin's direction bit is 0 and its enable bit is 1, a 0→1 change on that pin sets its pending bit. The bit becomes readable three clock edges after the change, at address 4 (port 0) or address 5 (port 1).
- R4: If a pin's direction bit is 1, a 1→0 change sets its pending bit and a 0→1 change does not.
- R5: An edge on a pin whose enable bit is 0 leaves its pending bit clear.
- R6: A pin held at a steady level never sets its pending bit, however long it is held.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Writing to a pending register never sets a bit.
- R8: If a qualifying edge and a write of 1 to the same pending bit fall in the same cycle, the pending bit remains set.
- R9: `irq` is high exactly when at least one pin has both its pending bit and its enable bit set. Disabling a pending pin drops `irq`, and its pending bit stays readable.
- R10: Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | 16 | Pin levels; bits 7:0 are port 0, bits 15:8 are port 1 |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Shared interrupt request |

## Verification
Two functions can fall in the same cycle: a pin's edge detection and a firmware write-one-to-clear of that same pin's pending bit. The bench provokes this by raising a pin that is already pending. It times the clear write so that its strobe is sampled on the third clock edge after the pin change, which is the edge on which the detection would set the flag. The pending bit must still read 1 afterwards. A clear issued one cycle after that edge, with no edge present, must drop the bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        PIN_CLEAR   = 1'b0,
        PIN_PENDING = 1'b1
    } pin_state_e;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_POL  = 2'd1,
        REG_PEND = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic fall_sel,
    input  logic clr,
    output logic pend
);
    pin_state_e state, nxt;
    logic       prev;
    logic       hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign hit = en && (fall_sel ? (prev && !lvl) : (!prev && lvl));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PIN_CLEAR;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            PIN_CLEAR:   if (hit) nxt = PIN_PENDING;
            PIN_PENDING: if (clr && !hit) nxt = PIN_CLEAR;
            default:     nxt = PIN_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        pend = (state == PIN_PENDING);
    end

    AST_EDGE_LATCH:   assert property (@(posedge clk) disable iff (!rst_n) hit |=> pend); // R3
    AST_W1C_DROP:     assert property (@(posedge clk) disable iff (!rst_n) (pend && clr && !hit) |=> !pend); // R7
    AST_RACE_KEEP:    assert property (@(posedge clk) disable iff (!rst_n) (pend && clr && hit) |=> pend); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!en && !pend) |=> !pend); // R5
    AST_NO_LEVEL:     assert property (@(posedge clk) disable iff (!rst_n) (!pend && (lvl == prev)) |=> !pend); // R6

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int PORT_W  = 8,
    parameter int N_PORTS = 2,
    parameter int ADDR_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic [PORT_W-1:0]           wdata,
    input  logic [PORT_W*N_PORTS-1:0]   pend_in,
    output logic [PORT_W*N_PORTS-1:0]   mask,
    output logic [PORT_W*N_PORTS-1:0]   pol,
    output logic [PORT_W*N_PORTS-1:0]   clr,
    output logic [PORT_W-1:0]           rdata
);
    localparam int PIDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(N_PORTS);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2 * N_PORTS);
    localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(3 * N_PORTS);

    reg_kind_e         kind;
    logic [ADDR_W-1:0] off;
    logic [PIDX_W-1:0] pidx;

    always_comb begin
        if (addr < A_POL) begin
            kind = REG_MASK;
            off  = addr;
        end else if (addr < A_PEND) begin
            kind = REG_POL;
            off  = addr - A_POL;
        end else if (addr < A_END) begin
            kind = REG_PEND;
            off  = addr - A_PEND;
        end else begin
            kind = REG_NONE;
            off  = '0;
        end
        pidx = PIDX_W'(off);
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[p*PORT_W +: PORT_W] <= '0;
                pol[p*PORT_W +: PORT_W]  <= '0;
            end else if (wr && (int'(pidx) == p)) begin
                if (kind == REG_MASK) mask[p*PORT_W +: PORT_W] <= wdata;
                if (kind == REG_POL)  pol[p*PORT_W +: PORT_W]  <= wdata;
            end
        end

        AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == ADDR_W'(p)) |=> (mask[p*PORT_W +: PORT_W] == $past(wdata))); // R2
    end

    always_comb begin
        clr = '0;
        if (wr && kind == REG_PEND) clr[pidx*PORT_W +: PORT_W] = wdata;
    end

    always_comb begin
        unique case (kind)
            REG_MASK: rdata = mask[pidx*PORT_W +: PORT_W];
            REG_POL:  rdata = pol[pidx*PORT_W +: PORT_W];
            REG_PEND: rdata = pend_in[pidx*PORT_W +: PORT_W];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int PORT_W  = 8,
    parameter int N_PORTS = 2,
    parameter int SYNC_ST = 2,
    parameter int ADDR_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORT_W*N_PORTS-1:0] gpio_in,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [PORT_W-1:0]         reg_wdata,
    output logic [PORT_W-1:0]         reg_rdata,
    output logic                      irq
);
    localparam int PINS = PORT_W * N_PORTS;

    logic [PINS-1:0] lvl;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] pol;
    logic [PINS-1:0] clr;
    logic [PINS-1:0] pend;

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_ST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (gpio_in),
        .dout (lvl)
    );

    gpio_irq_regs #(.PORT_W(PORT_W), .N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .pend_in(pend),
        .mask   (mask),
        .pol    (pol),
        .clr    (clr),
        .rdata  (reg_rdata)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_edge_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl     (lvl[i]),
            .en      (mask[i]),
            .fall_sel(pol[i]),
            .clr     (clr[i]),
            .pend    (pend[i])
        );
    end

    assign irq = |(pend & mask);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (mask != '0)); // R9

endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] gpio_in = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_pend(output logic [15:0] p);
        logic [7:0] lo, hi;
        rd(3'd4, lo);
        rd(3'd5, hi);
        p = {hi, lo};
    endtask

    function automatic logic [15:0] exp_pend(input logic [15:0] o, input logic [15:0] n,
                                             input logic [15:0] m, input logic [15:0] p);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++)
            if (m[i] && (p[i] ? (o[i] && !n[i]) : (!o[i] && n[i]))) r[i] = 1'b1;
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] p, old, nw, m, pl;
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset reg", {24'd0, d}, 32'd0);
        end
        chk("R1 reset irq", {31'd0, irq}, 32'd0);

        // R2 readback and R10 unused addresses
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h0F); wr(3'd3, 8'hF0);
        rd(3'd0, d); chk("R2 mask0", {24'd0, d}, 32'hA5);
        rd(3'd1, d); chk("R2 mask1", {24'd0, d}, 32'h3C);
        rd(3'd2, d); chk("R2 pol0", {24'd0, d}, 32'h0F);
        rd(3'd3, d); chk("R2 pol1", {24'd0, d}, 32'hF0);
        rd(3'd6, d); chk("R10 addr6", {24'd0, d}, 32'd0);
        rd(3'd7, d); chk("R10 addr7", {24'd0, d}, 32'd0);

        // R3 rising edge latency: not yet at 2 edges, set at 3
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gpio_in = 16'h0001;
        step(2);
        rd_pend(p); chk("R3 before latency", {16'd0, p}, 32'd0);
        step(1);
        rd_pend(p); chk("R3 rising set", {16'd0, p}, 32'h0001);
        chk("R9 irq high", {31'd0, irq}, 32'd1);

        // R6 steady level after clear
        wr(3'd4, 8'h01);
        step(20);
        rd_pend(p); chk("R6 steady high", {16'd0, p}, 32'd0);
        chk("R6 irq low", {31'd0, irq}, 32'd0);

        // R4 falling polarity: rise ignored, fall sets
        gpio_in = 16'h0000; step(4);
        wr(3'd1, 8'h80); wr(3'd3, 8'h80);
        gpio_in = 16'h8000; step(4);
        rd_pend(p); chk("R4 rise ignored", {16'd0, p}, 32'd0);
        gpio_in = 16'h0000; step(4);
        rd_pend(p); chk("R4 fall set", {16'd0, p}, 32'h8000);

        // R7 write zero keeps, write to clear-only register never sets
        wr(3'd5, 8'h00);
        rd_pend(p); chk("R7 zero write keeps", {16'd0, p}, 32'h8000);
        wr(3'd4, 8'hFF);
        rd_pend(p); chk("R7 no set by write", {16'd0, p}, 32'h8000);

        // R9 disable drops irq, pending stays
        wr(3'd1, 8'h00);
        chk("R9 irq off", {31'd0, irq}, 32'd0);
        rd_pend(p); chk("R9 pend kept", {16'd0, p}, 32'h8000);
        wr(3'd1, 8'h80);
        chk("R9 irq back", {31'd0, irq}, 32'd1);
        wr(3'd5, 8'h80);
        rd_pend(p); chk("R7 clear", {16'd0, p}, 32'd0);

        // R5 masked edge
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        gpio_in = 16'h0202; step(4);
        rd_pend(p); chk("R5 masked", {16'd0, p}, 32'd0);
        chk("R5 irq", {31'd0, irq}, 32'd0);

        // R8 race: pin 2 pending, then new rising edge meets clear
        wr(3'd0, 8'h04); wr(3'd2, 8'h00);
        gpio_in = 16'h0206; step(4);
        rd_pend(p); chk("R8 setup", {16'd0, p}, 32'h0004);
        gpio_in = 16'h0202; step(4);
        gpio_in = 16'h0206;
        step(2);
        wr(3'd4, 8'h04);
        rd_pend(p); chk("R8 race keeps", {16'd0, p}, 32'h0004);
        wr(3'd4, 8'h04);
        rd_pend(p); chk("R8 later clear", {16'd0, p}, 32'd0);

        // random patterns
        old = gpio_in;
        for (int it = 0; it < 60; it++) begin
            m  = 16'($urandom);
            pl = 16'($urandom);
            nw = 16'($urandom);
            wr(3'd0, m[7:0]); wr(3'd1, m[15:8]);
            wr(3'd2, pl[7:0]); wr(3'd3, pl[15:8]);
            wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
            gpio_in = nw;
            step(4);
            rd_pend(p);
            chk("R3 R4 R5 random pend", {16'd0, p}, {16'd0, exp_pend(old, nw, m, pl)});
            chk("R9 random irq", {31'd0, irq}, {31'd0, |(exp_pend(old, nw, m, pl) & m)});
            old = nw;
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule